// File: doc/BRIEF.md
# Sleep Entry and Watchdog Status Controller

This block decides when a small processor core may run and when its clock source must be held off. A one-cycle strobe from the core's sleep instruction puts the controller into an idle mode. In that single step it drops the oscillator enable, records that a sleep took place and marks the time-out status as clean. It also zeroes the watchdog count and its prescaler, so the watchdog interval starts afresh at the moment of sleep.

A free-running watchdog is built in. An 8-bit prescaler advances on every watchdog tick. Each time the prescaler wraps, the watchdog counter steps by one. When the counter is at its maximum and the prescaler wraps, a time-out occurs. The time-out clears the time-out status bit and, if the core is idle, restarts the oscillator. An external wake event also ends the idle mode, but it leaves the time-out status set. Software can therefore read the two status bits after waking and tell which cause woke it.

A synchronous active-low power-on reset returns everything to the running state with both status bits set.

Top module: `sleep_wdt_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is: `osc_en`=1, `no_sleep_flag`=1, `no_timeout_flag`=1, `wdt_count`=0, `wdt_prescale`=0.
- R2: When running and no sleep strobe is present, each cycle with `wdt_tick`=1 increments `wdt_prescale` by one, wrapping from all-ones to 0. `wdt_count` increments only on that wrap. With `wdt_tick`=0, both values hold.
- R3: A `sleep_req` strobe while running gives, on the next cycle, `osc_en`=0, `no_sleep_flag`=0, `no_timeout_flag`=1, `wdt_count`=0 and `wdt_prescale`=0. This takes precedence over a tick or a time-out in the same cycle.
- R4: While idle, `osc_en` stays 0 until a wake cause arrives. A further `sleep_req` while idle is ignored: it clears neither the prescaler nor the counter.
- R5: A `wake_evt` while idle sets `osc_en` to 1 on the next cycle. `no_timeout_flag` is unchanged and `no_sleep_flag` stays 0.
- R6: A time-out (`wdt_count` all-ones, `wdt_prescale` all-ones, `wdt_tick`=1) wraps both to 0 and clears `no_timeout_flag` on the next cycle. If the core is idle, it also sets `osc_en` to 1.
- R7: A `wake_evt` while running has no effect on `osc_en`, the status bits or the watchdog state.
- R8: The watchdog keeps counting ticks while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sleep_req | input | 1 | One-cycle strobe from the sleep instruction |
| wdt_tick | input | 1 | Watchdog time-base enable, one cycle per tick |
| wake_evt | input | 1 | External wake request |
| osc_en | output | 1 | Core oscillator enable, 0 while idle |
| no_sleep_flag | output | 1 | 1 after reset, 0 once a sleep has been entered |
| no_timeout_flag | output | 1 | 1 after reset or sleep entry, 0 after a watchdog time-out |
| wdt_count | output | CNT_W | Watchdog counter value |
| wdt_prescale | output | PRE_W | Watchdog prescaler value |

## Verification
A wrong prescaler value shows up at `wdt_prescale` on the very next tick. It reaches `wdt_count` only when the prescaler wraps, which can be up to 2^PRE_W ticks later. A corrupted mode bit shows up on `osc_en` in the cycle after it goes wrong. A wrong status flag can stay hidden until the next sleep strobe or time-out, because neither flag changes in between. For that reason the status bits are checked right after each sleep entry, each wake and each time-out. Time-out behaviour is checked with a reduced counter width, so that a full watchdog interval fits into a short run.

// File: rtl/sleep_wdt_pkg.sv
// Shared definitions for the sleep/watchdog controller.
// Assumes: a single power mode register encodes run versus idle.
package sleep_wdt_pkg;
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_IDLE = 1'b1
    } pwr_mode_e;
endpackage

// File: rtl/wdt_prescaler.sv
// Watchdog prescaler: counts ticks and flags the tick on which it wraps.
// Assumes: clr has priority over tick; reset is synchronous active-low.
module wdt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [PRE_W-1:0] count,
    output logic             wrap
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    // Wrap fires on a tick that takes the count from all-ones to zero.
    assign wrap = tick && (count == PRE_MAX);

    // Prescaler register: cleared on reset or sleep entry, else advanced by tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (tick) begin
            count <= count + PRE_W'(1);
        end
    end
endmodule

// File: rtl/wdt_counter.sv
// Watchdog counter: steps once per prescaler wrap and flags overflow.
// Assumes: step arrives at most once per cycle; clr has priority.
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Overflow is a step taken while the counter is already at its maximum.
    assign overflow = step && (count == CNT_MAX);

    // Counter register: cleared on reset or sleep entry, else stepped on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (step) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/power_status.sv
// Power mode and status flags: enters idle on a sleep strobe, leaves it on a
// wake event or watchdog overflow, and keeps the two status bits.
// Assumes: a sleep strobe while idle cannot occur legitimately and is ignored.
module power_status
    import sleep_wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_evt,
    input  logic overflow,
    output logic enter_sleep,
    output logic osc_en,
    output logic no_sleep_flag,
    output logic no_timeout_flag
);
    pwr_mode_e mode;

    // A sleep strobe counts only while the core is running.
    assign enter_sleep = sleep_req && (mode == MODE_RUN);
    assign osc_en      = (mode == MODE_RUN);

    // Mode and flag update: reset, then sleep entry, then overflow and wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode            <= MODE_RUN;
            no_sleep_flag   <= 1'b1;
            no_timeout_flag <= 1'b1;
        end else if (enter_sleep) begin
            mode            <= MODE_IDLE;
            no_sleep_flag   <= 1'b0;
            no_timeout_flag <= 1'b1;
        end else begin
            if (overflow) begin
                no_timeout_flag <= 1'b0;
            end
            if ((mode == MODE_IDLE) && (wake_evt || overflow)) begin
                mode <= MODE_RUN;
            end
        end
    end
endmodule

// File: rtl/sleep_wdt_ctrl.sv
// Top of the sleep/watchdog controller: ties prescaler, counter and power
// status together. Sleep entry clears the whole watchdog chain.
// Assumes: all inputs are synchronous to clk; reset is synchronous active-low.
module sleep_wdt_ctrl #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             wdt_tick,
    input  logic             wake_evt,
    output logic             osc_en,
    output logic             no_sleep_flag,
    output logic             no_timeout_flag,
    output logic [CNT_W-1:0] wdt_count,
    output logic [PRE_W-1:0] wdt_prescale
);
    logic enter_sleep;
    logic pre_wrap;
    logic cnt_overflow;

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (enter_sleep),
        .tick  (wdt_tick),
        .count (wdt_prescale),
        .wrap  (pre_wrap)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (enter_sleep),
        .step     (pre_wrap),
        .count    (wdt_count),
        .overflow (cnt_overflow)
    );

    power_status u_stat (
        .clk             (clk),
        .rst_n           (rst_n),
        .sleep_req       (sleep_req),
        .wake_evt        (wake_evt),
        .overflow        (cnt_overflow),
        .enter_sleep     (enter_sleep),
        .osc_en          (osc_en),
        .no_sleep_flag   (no_sleep_flag),
        .no_timeout_flag (no_timeout_flag)
    );
endmodule

// File: rtl/sleep_wdt_ctrl_chk.sv
// Port-level property checker for sleep_wdt_ctrl, attached by bind.
// Assumes: the same parameter values as the bound instance.
module sleep_wdt_ctrl_chk #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_req,
    input logic             wdt_tick,
    input logic             wake_evt,
    input logic             osc_en,
    input logic             no_sleep_flag,
    input logic             no_timeout_flag,
    input logic [CNT_W-1:0] wdt_count,
    input logic [PRE_W-1:0] wdt_prescale
);
    logic             rst_seen_q = 1'b0;
    logic [PRE_W-1:0] pre_inc;
    logic             sleeping_now;
    logic             time_out;

    assign pre_inc      = wdt_prescale + PRE_W'(1);
    assign sleeping_now = sleep_req && osc_en;
    assign time_out     = wdt_tick && (&wdt_prescale) && (&wdt_count);

    // Remember that reset was low at the previous edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1: state one cycle after a reset edge.
    always @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_state_R1: assert (osc_en && no_sleep_flag && no_timeout_flag
                                           && (wdt_count == '0) && (wdt_prescale == '0));
        end
    end

    assert_prescale_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_tick && !sleeping_now) |=> (wdt_prescale == $past(pre_inc)));

    assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_tick && !sleeping_now) |=> ($stable(wdt_prescale) && $stable(wdt_count)));

    assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping_now |=> (!osc_en && !no_sleep_flag && no_timeout_flag
                          && (wdt_count == '0) && (wdt_prescale == '0)));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !wake_evt && !time_out) |=> !osc_en);

    assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && wake_evt) |=> (osc_en && !no_sleep_flag));

    assert_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (time_out && !sleeping_now) |=> (!no_timeout_flag && osc_en
                                         && (wdt_count == '0) && (wdt_prescale == '0)));

    assert_run_wake_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && wake_evt && !sleep_req) |=> (osc_en && $stable(no_timeout_flag)
                                                && $stable(no_sleep_flag)));
endmodule

bind sleep_wdt_ctrl sleep_wdt_ctrl_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sleep_req       (sleep_req),
    .wdt_tick        (wdt_tick),
    .wake_evt        (wake_evt),
    .osc_en          (osc_en),
    .no_sleep_flag   (no_sleep_flag),
    .no_timeout_flag (no_timeout_flag),
    .wdt_count       (wdt_count),
    .wdt_prescale    (wdt_prescale)
);

// File: tb/tb_sleep_wdt_ctrl.sv
// Directed bench for sleep_wdt_ctrl, one task per scenario.
module tb_sleep_wdt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_W      = 8;
    localparam int CNT_W      = 4;
    localparam int FULL_TICKS = (1 << PRE_W) * (1 << CNT_W);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_req = 1'b0;
    logic             wdt_tick = 1'b0;
    logic             wake_evt = 1'b0;
    logic             osc_en;
    logic             no_sleep_flag;
    logic             no_timeout_flag;
    logic [CNT_W-1:0] wdt_count;
    logic [PRE_W-1:0] wdt_prescale;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    sleep_wdt_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sleep_req       (sleep_req),
        .wdt_tick        (wdt_tick),
        .wake_evt        (wake_evt),
        .osc_en          (osc_en),
        .no_sleep_flag   (no_sleep_flag),
        .no_timeout_flag (no_timeout_flag),
        .wdt_count       (wdt_count),
        .wdt_prescale    (wdt_prescale)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        wdt_tick = 1'b1;
        repeat (n) step();
        wdt_tick = 1'b0;
    endtask

    task automatic do_reset();
        sleep_req = 1'b0; wdt_tick = 1'b0; wake_evt = 1'b0;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1", "osc_en", int'(osc_en), 1);
        check("R1", "no_sleep_flag", int'(no_sleep_flag), 1);
        check("R1", "no_timeout_flag", int'(no_timeout_flag), 1);
        check("R1", "wdt_count", int'(wdt_count), 0);
        check("R1", "wdt_prescale", int'(wdt_prescale), 0);
    endtask

    task automatic t_prescale_chain();
        do_reset();
        do_ticks(5);
        check("R2", "prescale after 5 ticks", int'(wdt_prescale), 5);
        check("R2", "count after 5 ticks", int'(wdt_count), 0);
        repeat (3) step();
        check("R2", "prescale held without tick", int'(wdt_prescale), 5);
        do_ticks(250);
        check("R2", "prescale at all-ones", int'(wdt_prescale), 255);
        check("R2", "count before wrap", int'(wdt_count), 0);
        do_ticks(1);
        check("R2", "prescale wrapped", int'(wdt_prescale), 0);
        check("R2", "count stepped on wrap", int'(wdt_count), 1);
    endtask

    task automatic t_sleep_idle_wake();
        do_reset();
        do_ticks(300);
        sleep_req = 1'b1; wdt_tick = 1'b1;
        step();
        sleep_req = 1'b0; wdt_tick = 1'b0;
        check("R3", "osc_en after sleep", int'(osc_en), 0);
        check("R3", "no_sleep_flag after sleep", int'(no_sleep_flag), 0);
        check("R3", "no_timeout_flag after sleep", int'(no_timeout_flag), 1);
        check("R3", "count cleared over tick", int'(wdt_count), 0);
        check("R3", "prescale cleared over tick", int'(wdt_prescale), 0);
        do_ticks(3);
        check("R8", "prescale counts while idle", int'(wdt_prescale), 3);
        sleep_req = 1'b1; wdt_tick = 1'b1;
        step();
        sleep_req = 1'b0; wdt_tick = 1'b0;
        check("R4", "repeat sleep ignored, prescale", int'(wdt_prescale), 4);
        check("R4", "osc_en held while idle", int'(osc_en), 0);
        repeat (4) step();
        check("R4", "osc_en still off", int'(osc_en), 0);
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
        check("R5", "osc_en after wake", int'(osc_en), 1);
        check("R5", "no_timeout_flag after wake", int'(no_timeout_flag), 1);
        check("R5", "no_sleep_flag stays low", int'(no_sleep_flag), 0);
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
        check("R7", "osc_en on run wake", int'(osc_en), 1);
        check("R7", "prescale on run wake", int'(wdt_prescale), 4);
        check("R7", "no_timeout_flag on run wake", int'(no_timeout_flag), 1);
        check("R7", "no_sleep_flag on run wake", int'(no_sleep_flag), 0);
    endtask

    task automatic t_timeout_while_idle();
        do_reset();
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        do_ticks(FULL_TICKS - 1);
        check("R8", "osc_en before time-out", int'(osc_en), 0);
        check("R8", "count at max while idle", int'(wdt_count), (1 << CNT_W) - 1);
        do_ticks(1);
        check("R6", "osc_en after idle time-out", int'(osc_en), 1);
        check("R6", "no_timeout_flag after time-out", int'(no_timeout_flag), 0);
        check("R6", "count wrapped", int'(wdt_count), 0);
        check("R6", "prescale wrapped", int'(wdt_prescale), 0);
    endtask

    task automatic t_timeout_while_running();
        do_reset();
        do_ticks(FULL_TICKS);
        check("R6", "running time-out flag", int'(no_timeout_flag), 0);
        check("R6", "running time-out osc_en", int'(osc_en), 1);
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        check("R3", "sleep sets no_timeout_flag again", int'(no_timeout_flag), 1);
        check("R3", "sleep after time-out osc_en", int'(osc_en), 0);
    endtask

    task automatic t_sleep_beats_timeout();
        do_reset();
        do_ticks(FULL_TICKS - 1);
        sleep_req = 1'b1; wdt_tick = 1'b1;
        step();
        sleep_req = 1'b0; wdt_tick = 1'b0;
        check("R3", "sleep over time-out flag", int'(no_timeout_flag), 1);
        check("R3", "sleep over time-out count", int'(wdt_count), 0);
        check("R3", "sleep over time-out osc_en", int'(osc_en), 0);
    endtask

    initial begin
        t_reset_state();
        t_prescale_chain();
        t_sleep_idle_wake();
        t_timeout_while_idle();
        t_timeout_while_running();
        t_sleep_beats_timeout();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule